// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control for a successive-approximation converter built around a binary-weighted switched-capacitor DAC. While it is idle, the block holds the array in acquisition: the sampling switches are closed, the array tracks the inputs and the analog core is powered down. A rising edge on the convert input starts a conversion. The block first opens the sampling switches. One internal clock later it moves the array off the inputs and onto the ground/reference switches. It then decides the code one bit at a time, most significant bit first.

Each bit trial takes two internal clocks. In the first, the trial bit is driven to reference and the comparator settles. At the end of the second, the comparator decision is registered: a high decision keeps the bit and a low decision clears it. When the last bit has been decided, the block publishes the code and drops busy on the same edge. It then returns to acquisition and powers down. The code therefore belongs to the conversion that has just finished and carries no pipeline latency.

The sequencer runs on its own conversion clock. No serial clock is needed to convert. Inputs above full scale come out as all ones and inputs below ground come out as all zeros, because the comparator decides every trial the same way.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset, and at all times while not busy, samp_close_o=1, arr_hold_o=0, dac_sw_o=0 and busy_o=0. After reset code_o=0.
- R2: A rising edge of cnv_i, passed through SYNC_STAGES synchronizer flops, starts a conversion and raises busy_o. Holding cnv_i high after a conversion ends does not start another one.
- R3: At the start of a conversion samp_close_o falls first. arr_hold_o rises exactly one clock later.
- R4: On the clock where arr_hold_o rises, dac_sw_o equals 0x8000 (only the MSB trial bit set). Each trial bit stays set for two clocks before the decision, and the next lower bit is then set.
- R5: A comparator decision cmp_i=1 (input at or above the trial code) keeps the trial bit; cmp_i=0 clears it. The final code is the largest code not above the input.
- R6: busy_o stays high for exactly 1+2*NBITS clocks (33 with the defaults). code_o takes the new result on the same edge at which busy_o falls.
- R7: An input above full scale gives 0xFFFF, an input below ground gives 0x0000, and midscale gives 0x8000.
- R8: pwr_en_o is high during a conversion and low during acquisition.
- R9: Rising edges of cnv_i while busy_o is high are ignored. The conversion length is unchanged and no second conversion follows.
- R10: code_o holds the previous result for the whole of the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Convert trigger; a rising edge starts a conversion |
| cmp_i | input | 1 | Comparator decision; 1 means the input is at or above the trial code |
| samp_close_o | output | 1 | 1 closes the sampling switches (acquisition) |
| arr_hold_o | output | 1 | 1 connects the array to the ground/reference switches |
| dac_sw_o | output | NBITS | Per-bit switch: 1 selects reference, 0 selects ground |
| busy_o | output | 1 | High while a conversion is in progress |
| pwr_en_o | output | 1 | Analog core power enable |
| code_o | output | NBITS | Last conversion result, straight binary |

## Verification
If the bit index or phase is corrupted, the trial pattern on dac_sw_o goes wrong within two clocks of the error. The final code on code_o is then wrong, which shows as soon as busy_o falls. If the control state is corrupted, the busy interval is no longer 33 clocks, or the switch ordering between samp_close_o and arr_hold_o breaks on the first clock of a conversion. Both are measured at the ports on every conversion. A start gate that wrongly accepts triggers would show as a stretched or repeated busy interval after a mid-conversion trigger, or after cnv_i has been held high.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_OPEN  = 2'd1,
    ST_TRIAL = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_cnv_edge.sv
module sar_cnv_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cnv_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 last_q;

  assign sync_q[0] = cnv_i;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s+1] <= 1'b0;
      else         sync_q[s+1] <= sync_q[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES];
  end

  assign rise_o = sync_q[SYNC_STAGES] & ~last_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NBITS = 16,
  localparam int IDXW = $clog2(NBITS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output sar_state_e      state_o,
  output logic [IDXW-1:0] idx_o,
  output logic            load_msb_o,
  output logic            decide_o,
  output logic            last_o
);
  sar_state_e      state_q;
  logic [IDXW-1:0] idx_q;
  logic            ph_q;  // 0: trial set / settling, 1: decide at end of cycle

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACQ;
      idx_q   <= '0;
      ph_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ACQ: if (start_i) state_q <= ST_OPEN;  // triggers accepted only here
        ST_OPEN: begin
          state_q <= ST_TRIAL;
          idx_q   <= IDXW'(NBITS - 1);
          ph_q    <= 1'b0;
        end
        ST_TRIAL: begin
          if (!ph_q) begin
            ph_q <= 1'b1;
          end else if (idx_q == '0) begin
            state_q <= ST_ACQ;
            ph_q    <= 1'b0;
          end else begin
            idx_q <= idx_q - 1'b1;
            ph_q  <= 1'b0;
          end
        end
        default: state_q <= ST_ACQ;
      endcase
    end
  end

  assign state_o    = state_q;
  assign idx_o      = idx_q;
  assign load_msb_o = (state_q == ST_OPEN);
  assign decide_o   = (state_q == ST_TRIAL) && ph_q;
  assign last_o     = decide_o && (idx_q == '0);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int NBITS = 16,
  localparam int IDXW = $clog2(NBITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_msb_i,
  input  logic             decide_i,
  input  logic             last_i,
  input  logic [IDXW-1:0]  idx_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] code_o
);
  logic [NBITS-1:0] trial_q, code_q, decided;

  // Resolve bit idx from the comparator and raise the next lower trial bit.
  always_comb begin
    decided = trial_q;
    for (int b = 0; b < NBITS; b++) begin
      if (b == int'(idx_i))          decided[b] = cmp_i;
      else if (b + 1 == int'(idx_i)) decided[b] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      code_q  <= '0;
    end else if (load_msb_i) begin
      trial_q <= {1'b1, {(NBITS-1){1'b0}}};
    end else if (decide_i) begin
      if (last_i) begin
        code_q  <= decided;
        trial_q <= '0;
      end else begin
        trial_q <= decided;
      end
    end
  end

  assign trial_o = trial_q;
  assign code_o  = code_q;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int NBITS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnv_i,
  input  logic             cmp_i,
  output logic             samp_close_o,
  output logic             arr_hold_o,
  output logic [NBITS-1:0] dac_sw_o,
  output logic             busy_o,
  output logic             pwr_en_o,
  output logic [NBITS-1:0] code_o
);
  localparam int IDXW = $clog2(NBITS);

  sar_state_e      state;
  logic            rise, start, load_msb, decide, last;
  logic [IDXW-1:0] idx;

  sar_cnv_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnv_i  (cnv_i),
    .rise_o (rise)
  );

  assign start = rise && (state == ST_ACQ);

  sar_ctrl #(.NBITS(NBITS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .state_o    (state),
    .idx_o      (idx),
    .load_msb_o (load_msb),
    .decide_o   (decide),
    .last_o     (last)
  );

  sar_trial_reg #(.NBITS(NBITS)) i_trial (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_msb_i (load_msb),
    .decide_i   (decide),
    .last_i     (last),
    .idx_i      (idx),
    .cmp_i      (cmp_i),
    .trial_o    (dac_sw_o),
    .code_o     (code_o)
  );

  assign samp_close_o = (state == ST_ACQ);
  assign arr_hold_o   = (state == ST_TRIAL);
  assign busy_o       = (state != ST_ACQ);
  assign pwr_en_o     = (state != ST_ACQ);  // analog core off between conversions
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int NBITS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             samp_close_o,
  input logic             arr_hold_o,
  input logic [NBITS-1:0] dac_sw_o,
  input logic             busy_o,
  input logic [NBITS-1:0] code_o
);
  localparam int unsigned CONV_CYC = 1 + 2 * NBITS;

  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  p_acq_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (samp_close_o && !arr_hold_o && dac_sw_o == '0));

  p_switch_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_hold_o) |-> (!samp_close_o && $past(!samp_close_o)));

  p_msb_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_hold_o) |-> dac_sw_o == {1'b1, {(NBITS-1){1'b0}}});

  p_busy_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt == CONV_CYC);

  p_busy_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_cnt <= CONV_CYC);

  p_code_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $stable(code_o));
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.NBITS(NBITS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .samp_close_o (samp_close_o),
  .arr_hold_o   (arr_hold_o),
  .dac_sw_o     (dac_sw_o),
  .busy_o       (busy_o),
  .code_o       (code_o)
);

// File: tb/test_sar_conv_seq.sv
module test_sar_conv_seq;
  localparam int N       = 16;
  localparam int CONV    = 1 + 2 * N;
  localparam int NVEC    = 11;
  localparam int VEC_IN [NVEC] = '{0, 1, 32768, 32767, 65535, 65534, 70000, -5, 12345, 43690, 21845};
  localparam logic [N-1:0] VEC_EXP [NVEC] = '{16'h0000, 16'h0001, 16'h8000, 16'h7FFF, 16'hFFFF,
                                             16'hFFFE, 16'hFFFF, 16'h0000, 16'h3039, 16'hAAAA, 16'h5555};

  logic clk = 1'b0, rst_n = 1'b0, cnv = 1'b0, cmp;
  logic samp, hold, busy, pwr;
  logic [N-1:0] dac, code;
  int   vin = 0;
  int   errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  // Comparator model: held input against trial DAC code.
  assign cmp = hold && (vin >= int'(dac));

  sar_conv_seq i_sar_conv_seq (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .cmp_i(cmp),
    .samp_close_o(samp), .arr_hold_o(hold), .dac_sw_o(dac),
    .busy_o(busy), .pwr_en_o(pwr), .code_o(code)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input logic [N-1:0] exp, input logic [N-1:0] prev,
                          input string req, input bit glitch);
    int n = 0;
    bit held = 1'b1;
    vin = v;
    @(negedge clk); cnv = 1'b1;
    while (!busy && n < 10) begin @(negedge clk); n++; end
    chk(busy, "R2 start", 32'(busy), 1);
    chk(!samp && !hold, "R3 open first", {samp, hold}, 0);
    chk(pwr, "R8 power on", 32'(pwr), 1);
    n = 1;
    @(negedge clk); n++;
    chk(hold && !samp, "R3 hold next", {samp, hold}, 2'b01);
    chk(dac == 16'h8000, "R4 msb trial", dac, 16'h8000);
    @(negedge clk); n++;
    chk(dac == 16'h8000, "R4 settle", dac, 16'h8000);
    @(negedge clk); n++;
    chk(dac[15] == (v >= 32768) && dac[14], "R5 msb decided", dac, {(v >= 32768), 1'b1, 14'h0});
    forever begin
      if (code !== prev) held = 1'b0;
      if (glitch && n == 10) cnv = 1'b0;
      if (glitch && n == 12) cnv = 1'b1;
      @(negedge clk);
      if (!busy || n > 100) break;
      n++;
    end
    chk(held, "R10 code held", 32'(held), 1);
    chk(n == CONV, glitch ? "R9 length" : "R6 length", n, CONV);
    chk(code == exp, req, code, exp);
    chk(!pwr && samp, "R8 power down", {pwr, samp}, 2'b01);
  endtask

  initial begin
    logic [N-1:0] prev;
    repeat (3) @(negedge clk);
    chk(!busy && samp && !hold && !pwr && dac == 0 && code == 0, "R1 reset",
        {busy, samp, hold, pwr, dac == 0, code == 0}, 6'b010011);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && samp, "R1 idle", {busy, samp}, 2'b01);

    prev = '0;
    for (int i = 0; i < NVEC; i++) begin
      run_conv(VEC_IN[i], VEC_EXP[i], prev,
               (VEC_IN[i] > 65535 || VEC_IN[i] < 0 || VEC_IN[i] == 32768) ? "R7 range" : "R5 code", 1'b0);
      prev = VEC_EXP[i];
      repeat (6) @(negedge clk);
      chk(!busy, "R2 level no retrigger", 32'(busy), 0);
      cnv = 1'b0;
      repeat (4) @(negedge clk);
    end

    // Trigger during busy must be ignored.
    run_conv(40000, 16'd40000, prev, "R9 code", 1'b1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (busy) begin chk(0, "R9 no retrigger", 32'(busy), 0); break; end
    end
    checks++;
    chk(code == 16'd40000, "R10 code after", code, 16'd40000);
    cnv = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule